// File: doc/BRIEF.md
# PHY Management Interface Master

This block lets a processor reach the management registers of external Ethernet PHYs over the two-wire management bus: a clock line (MDC) and a shared bidirectional data line (MDIO). Software sees four 32-bit registers on a simple write-strobe bus with combinational read-back.

The four registers are:
- a configuration word holding the clock divisor and an enable bit;
- a command word that launches a transaction and reports readiness;
- a write-data word;
- a read-data word.

One write to the command word carries the whole transaction: the PHY address, the register address, the direction, and a launch bit. The block then shifts out a complete management frame. The frame is made of a preamble of ones, the start pattern, the opcode, both addresses and the turnaround. After that it either sends the 16-bit write value or releases the line and collects the 16 bits the PHY returns. The MDIO pin is split into an output, an output enable and an input. The pad and its pull-up sit outside this block.

Software polls the ready flag in the command word. When ready returns to 1 after a read, the read-data word holds the value the PHY returned. A PHY address with no device behind it reads back as all ones, because the pulled-up line is never driven low.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the configuration word (offset 0x00) reads divisor bits [5:0] = 29 and enable bit [6] = 0. The command word (offset 0x04) reads ready bit [7] = 1. The read-data word (offset 0x0C) reads 0.
- R2: While a frame runs, MDC toggles every divisor+1 system clocks, so its period is 2×(divisor+1) clocks. MDC rests low whenever no frame is running.
- R3: A frame is 64 MDC cycles long, MSB first, and MDIO changes only while MDC is low. It carries, in order:
  - 32 ones;
  - the start pattern 01;
  - the opcode, 10 for a read (command bit 15) or 01 for a write (command bit 14);
  - the 5-bit PHY address from command bits [28:24];
  - the 5-bit register address from command bits [20:16].
- R4: In a write frame, the turnaround is driven as 10 and is followed by bits [15:0] of the write-data word (offset 0x08). That value is captured when the frame is launched.
- R5: In a read frame, the output enable is 0 for the two turnaround bits and the 16 data bits. The data bits are sampled on rising MDC edges. When ready returns to 1, the value appears in bits [15:0] of the read-data word.
- R6: A read of a PHY address that no device answers returns 0xFFFF.
- R7: Ready (command bit 7) reads 0 from the cycle after a launch until the frame ends. The launch bit (command bit 11) always reads back as 0.
- R8: A launch written while ready is 0 is ignored: no second frame is sent, and the latched address fields are unchanged.
- R9: While the enable bit is 0, a launch is ignored and MDC does not change.
- R10: A launch whose opcode bits 15 and 14 are both 1 or both 0 sends no frame, and ready stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data, output value |
| mdio_oe | output | 1 | Management data, output enable |
| mdio_i | input | 1 | Management data, line value (pulled up outside) |

## Verification
The assertions take three things for granted about the inputs:
- a launch is only ever passed to the frame engine while it is idle;
- the divider only ticks during a frame;
- the management input is already a clean, synchronous level when it is sampled.

The bench meets the third point by driving the PHY model's data one nanosecond after each falling MDC edge. The data is therefore stable for at least one system clock before the rising edge that samples it. Each random transaction first writes the configuration word with a small divisor and the enable set. It launches only when ready reads 1. Launches made while the block is busy, while it is disabled, or with an invalid opcode are issued as directed cases.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    // register byte offsets
    localparam logic [3:0] OFS_CFG  = 4'h0;
    localparam logic [3:0] OFS_CMD  = 4'h4;
    localparam logic [3:0] OFS_WDAT = 4'h8;
    localparam logic [3:0] OFS_RDAT = 4'hC;

    // command word bit positions
    localparam int CMD_PHY_LSB = 24;
    localparam int CMD_REG_LSB = 16;
    localparam int CMD_RD_BIT  = 15;
    localparam int CMD_WR_BIT  = 14;
    localparam int CMD_GO_BIT  = 11;
    localparam int CMD_RDY_BIT = 7;

    // configuration word
    localparam int CFG_EN_BIT  = 6;
    localparam int DIV_W       = 6;
    localparam logic [DIV_W-1:0] DIV_RESET = 6'd29;

    localparam int ADDR_BITS   = 5;
    localparam int DATA_BITS   = 16;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    // >= keeps a shrinking divisor from causing a long wrap
    assign tick_o = run_i && (cnt_q >= div_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)        cnt_d = '0;
        else if (tick_o)  cnt_d = '0;
        else if (run_i)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 is_read_i,
    input  logic [ADDR_BITS-1:0] phy_i,
    input  logic [ADDR_BITS-1:0] reg_i,
    input  logic [DATA_BITS-1:0] wdata_i,
    input  logic                 tick_i,
    input  logic                 mdio_i,
    output logic                 mdc_o,
    output logic                 mdio_o,
    output logic                 mdio_oe_o,
    output logic                 busy_o,
    output logic [DATA_BITS-1:0] rdata_o
);
    localparam int FRAME_LEN = PRE_BITS + 4 + 2*ADDR_BITS + 2 + DATA_BITS;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_LEN - DATA_BITS - 2);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(FRAME_LEN - DATA_BITS);

    typedef struct packed {
        logic                 busy;
        logic                 mdc;
        logic                 rd;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] frame;
        logic [DATA_BITS-1:0] shift;
        logic [DATA_BITS-1:0] rdata;
    } eng_t;

    eng_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i && !s_q.busy) begin
            s_d.busy  = 1'b1;
            s_d.mdc   = 1'b0;
            s_d.rd    = is_read_i;
            s_d.idx   = '0;
            s_d.frame = {{PRE_BITS{1'b1}}, 2'b01,
                         (is_read_i ? 2'b10 : 2'b01), phy_i, reg_i,
                         (is_read_i ? 2'b11 : 2'b10),
                         (is_read_i ? {DATA_BITS{1'b1}} : wdata_i)};
        end else if (s_q.busy && tick_i) begin
            if (!s_q.mdc) begin
                s_d.mdc = 1'b1;
                if (s_q.rd && s_q.idx >= DAT_IDX)
                    s_d.shift = {s_q.shift[DATA_BITS-2:0], mdio_i};
            end else begin
                s_d.mdc = 1'b0;
                if (s_q.idx == LAST_IDX) begin
                    s_d.busy = 1'b0;
                    if (s_q.rd) s_d.rdata = s_q.shift;
                end else begin
                    s_d.idx   = s_q.idx + 1'b1;
                    s_d.frame = {s_q.frame[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc_o     = s_q.mdc;
    assign mdio_o    = s_q.frame[FRAME_LEN-1];
    assign mdio_oe_o = s_q.busy && !(s_q.rd && s_q.idx >= TA_IDX);
    assign busy_o    = s_q.busy;
    assign rdata_o   = s_q.rdata;

    // R2: clock rests low between frames
    p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> !s_q.mdc);
    // R2: divider ticks only arrive during a frame
    p_tick_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |-> s_q.busy);
    // R8: the register side never launches into a running frame
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_q.busy);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [DIV_W-1:0]     div;
        logic                 en;
        logic [ADDR_BITS-1:0] phy;
        logic [ADDR_BITS-1:0] regad;
        logic                 op_rd;
        logic                 op_wr;
        logic [DATA_BITS-1:0] wdat;
    } regs_t;

    regs_t r_d, r_q;
    logic  busy, tick, launch, go_req, op_ok;
    logic [DATA_BITS-1:0] rd_val;

    assign go_req = reg_wr && (reg_addr == OFS_CMD) && reg_wdata[CMD_GO_BIT];
    assign op_ok  = reg_wdata[CMD_RD_BIT] ^ reg_wdata[CMD_WR_BIT];
    assign launch = go_req && op_ok && r_q.en && !busy;

    always_comb begin
        r_d = r_q;
        if (reg_wr && reg_addr == OFS_CFG) begin
            r_d.div = reg_wdata[DIV_W-1:0];
            r_d.en  = reg_wdata[CFG_EN_BIT];
        end
        if (reg_wr && reg_addr == OFS_WDAT)
            r_d.wdat = reg_wdata[DATA_BITS-1:0];
        if (launch) begin
            r_d.phy   = reg_wdata[CMD_PHY_LSB +: ADDR_BITS];
            r_d.regad = reg_wdata[CMD_REG_LSB +: ADDR_BITS];
            r_d.op_rd = reg_wdata[CMD_RD_BIT];
            r_d.op_wr = reg_wdata[CMD_WR_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.div <= DIV_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CFG: begin
                reg_rdata[DIV_W-1:0]  = r_q.div;
                reg_rdata[CFG_EN_BIT] = r_q.en;
            end
            OFS_CMD: begin
                reg_rdata[CMD_PHY_LSB +: ADDR_BITS] = r_q.phy;
                reg_rdata[CMD_REG_LSB +: ADDR_BITS] = r_q.regad;
                reg_rdata[CMD_RD_BIT]  = r_q.op_rd;
                reg_rdata[CMD_WR_BIT]  = r_q.op_wr;
                reg_rdata[CMD_RDY_BIT] = !busy;
            end
            OFS_WDAT: reg_rdata[DATA_BITS-1:0] = r_q.wdat;
            OFS_RDAT: reg_rdata[DATA_BITS-1:0] = rd_val;
            default:  reg_rdata = '0;
        endcase
    end

    mdio_clk_div u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (launch),
        .run_i  (busy && r_q.en),
        .div_i  (r_q.div),
        .tick_o (tick)
    );

    mdio_frame_eng #(.PRE_BITS(PRE_BITS)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (launch),
        .is_read_i (reg_wdata[CMD_RD_BIT]),
        .phy_i     (reg_wdata[CMD_PHY_LSB +: ADDR_BITS]),
        .reg_i     (reg_wdata[CMD_REG_LSB +: ADDR_BITS]),
        .wdata_i   (r_q.wdat),
        .tick_i    (tick),
        .mdio_i    (mdio_i),
        .mdc_o     (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .busy_o    (busy),
        .rdata_o   (rd_val)
    );

    // R9: a disabled interface keeps its clock still
    p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |=> $stable(mdc));
    // R10: a malformed opcode leaves the block idle
    p_bad_op_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !op_ok && !busy) |=> !busy);
    // R5: output driver never on while a read result is being latched
    p_read_end_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && r_q.op_rd) |-> $past(!mdio_oe));
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
    localparam logic [3:0] A_CFG = 4'h0, A_CMD = 4'h4, A_WDAT = 4'h8, A_RDAT = 4'hC;
    localparam logic [4:0] PHY_A = 5'h03, PHY_B = 5'h11;

    logic clk = 0, rst_n = 0, reg_wr = 0, mdio_i = 1;
    logic [3:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mdc, mdio_o, mdio_oe;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0, fails = 0;
    int cyc = 0, rise_cnt = 0, last_rise = 0, last_per = 0, frames = 0;
    int cap_cnt = 64;
    logic late_oe = 0;
    logic [63:0] cap = 0;
    logic [15:0] phy_mem [2][32];
    logic [15:0] exp_mem [2][32];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int phy_slot(input logic [4:0] a);
        return (a == PHY_A) ? 0 : (a == PHY_B) ? 1 : -1;
    endfunction

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
    endfunction

    // bus sampler on rising MDC: records frame bits and the write effect on a PHY
    initial forever begin
        @(posedge mdc); #1;
        rise_cnt++;
        if (cap_cnt > 0 && cap_cnt < 64) last_per = cyc - last_rise;
        last_rise = cyc;
        if (cap_cnt < 64) begin
            cap[63-cap_cnt] = mdio_oe ? mdio_o : 1'b1;
            if (cap_cnt >= 46 && mdio_oe && cap[63-34]) late_oe = 1;
            cap_cnt++;
            if (cap_cnt == 64) begin
                frames++;
                if (cap[29:28] == 2'b01 && phy_slot(cap[27:23]) >= 0)
                    phy_mem[phy_slot(cap[27:23])][cap[22:18]] = cap[15:0];
            end
        end
    end

    // PHY answer driver on falling MDC
    initial forever begin
        @(negedge mdc); #1;
        if (cap[29:28] == 2'b10 && phy_slot(cap[27:23]) >= 0 && cap_cnt >= 47 && cap_cnt <= 63) begin
            if (cap_cnt == 47) mdio_i = 1'b0;
            else mdio_i = phy_mem[phy_slot(cap[27:23])][cap[22:18]][15-(cap_cnt-48)];
        end else mdio_i = 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_ready();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            bus_rd(A_CMD, v);
            if (v[7]) break;
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic rd, input logic wr,
                                             input logic [4:0] p, input logic [4:0] r);
        logic [31:0] w = 0;
        w[28:24] = p; w[20:16] = r; w[15] = rd; w[14] = wr; w[11] = 1'b1;
        return w;
    endfunction

    // one full transaction with frame and result checks
    task automatic txn(input logic rd, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input logic [5:0] div);
        logic [31:0] v;
        bus_wr(A_CFG, {25'd0, 1'b1, div});
        bus_wr(A_WDAT, {16'd0, d});
        cap_cnt = 0; late_oe = 0;
        bus_wr(A_CMD, cmd_word(rd, !rd, p, r));
        bus_rd(A_CMD, v);
        check("R7 ready low in frame", {30'd0, v[11], v[7]}, 32'd0);
        wait_ready();
        check("R2 mdc period", last_per, 2*(div+1));
        if (rd) begin
            check("R3 read header", {2'b0, cap[63:34]}, {2'b0, exp_frame(1, p, r, 0) >> 34});
            check("R5 line released", {31'd0, late_oe}, 0);
            bus_rd(A_RDAT, v);
            if (phy_slot(p) < 0) check("R6 absent phy", v, 32'h0000_FFFF);
            else check("R5 read data", v, {16'd0, exp_mem[phy_slot(p)][r]});
        end else begin
            check("R3/R4 write frame hi", cap[63:32], exp_frame(0, p, r, d) >> 32);
            check("R4 write frame lo", cap[31:0], exp_frame(0, p, r, d) & 64'hFFFF_FFFF);
            if (phy_slot(p) >= 0) exp_mem[phy_slot(p)][r] = d;
        end
    endtask

    initial begin
        #1200000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0, fr0;
        void'($urandom(32'd7421));
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 32; k++) begin
                phy_mem[s][k] = 16'($urandom);
                exp_mem[s][k] = phy_mem[s][k];
            end
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        bus_rd(A_CFG, v);  check("R1 cfg reset", v, 32'd29);
        bus_rd(A_CMD, v);  check("R1 ready after reset", {31'd0, v[7]}, 1);
        bus_rd(A_RDAT, v); check("R1 rdata reset", v, 0);

        // directed: read then write then readback, absent phy
        txn(1, PHY_A, 5'd1, 0, 6'd0);
        txn(0, PHY_A, 5'd1, 16'hA55A, 6'd1);
        txn(1, PHY_A, 5'd1, 0, 6'd3);
        txn(1, 5'h1F, 5'd2, 0, 6'd0);
        txn(0, 5'h00, 5'd31, 16'h0001, 6'd2);

        // R9 disabled: launch ignored, MDC still
        bus_wr(A_CFG, {25'd0, 1'b0, 6'd0});
        r0 = rise_cnt;
        bus_wr(A_CMD, cmd_word(1, 0, PHY_A, 5'd4));
        repeat (60) @(negedge clk);
        check("R9 no mdc when disabled", rise_cnt, r0);
        bus_rd(A_CMD, v); check("R9 ready stays", {31'd0, v[7]}, 1);

        // R10 invalid opcode (both, neither)
        bus_wr(A_CFG, {25'd0, 1'b1, 6'd0});
        r0 = rise_cnt;
        bus_wr(A_CMD, cmd_word(1, 1, PHY_A, 5'd4));
        bus_rd(A_CMD, v); check("R10 both bits ready", {31'd0, v[7]}, 1);
        bus_wr(A_CMD, cmd_word(0, 0, PHY_A, 5'd4));
        repeat (60) @(negedge clk);
        check("R10 no frame", rise_cnt, r0);

        // R8 launch while busy ignored
        fr0 = frames;
        cap_cnt = 0;
        bus_wr(A_CMD, cmd_word(1, 0, PHY_B, 5'd6));
        repeat (10) @(negedge clk);
        bus_wr(A_CMD, cmd_word(0, 1, 5'h09, 5'd7));
        wait_ready();
        r0 = rise_cnt;
        repeat (80) @(negedge clk);
        check("R8 no second frame", rise_cnt, r0);
        check("R8 one frame sent", frames - fr0, 1);
        bus_rd(A_CMD, v);
        check("R8 fields kept", {v[28:24], v[20:16], v[15], v[14]}, {PHY_B, 5'd6, 2'b10});
        bus_rd(A_RDAT, v);
        check("R5 busy-case read data", v, {16'd0, exp_mem[1][6]});

        // random mix
        for (int t = 0; t < 30; t++) begin
            logic [4:0] p;
            case ($urandom % 3)
                0: p = PHY_A;
                1: p = PHY_B;
                default: p = 5'($urandom);
            endcase
            txn(1'($urandom), p, 5'($urandom), 16'($urandom), 6'($urandom % 4));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule